// File: doc/BRIEF.md
# Cascaded Second-Order-Section IIR Filter

This block filters a stream of signed fixed-point samples through a recursive (infinite impulse response) filter. The filter is split into a serial chain of second-order sections. When the total order is odd, the last section is first-order. A single gain constant scales each sample before it enters the chain. Every section keeps its internal state in registers of one shared width. Each section output is rounded and clamped to that width before it drives the next section, so the chain never wraps around on overflow.

All coefficients are fixed at elaboration through parameters, in fractional fixed point. The denominator of every section is normalised to a leading one. A new sample is taken on every clock edge where the clock enable is high. With the enable low, the whole datapath freezes. An active-low asynchronous reset clears the block. Its release is resynchronised internally, so the datapath starts to move only on the third clock edge after the reset input goes high.

Top module: `iir_cascade`

## Requirements
- R1: While `rst_n` is low, `yout` is 0 and every state and pipeline register is cleared. Clearing takes effect without waiting for a clock edge.
- R2: The gain stage registers g = clamp(round(xin·GAIN / 2^GSH)). The result is signed, DW bits wide, and GAIN is a signed CW-bit value.
- R3: Every requantised value is clamped to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1] and never wraps. This covers the gain-stage result and each section's state and output. With GAIN > 0, a positive xin gives g ≥ 0 and a negative xin gives g ≤ 0.
- R4: Requantisation by a right shift of s bits adds 2^(s-1) and then shifts arithmetically. The result is rounded to nearest, with exact halves going toward plus infinity (2441.5 → 2442, -312.5 → -312).
- R5: A second-order section with input u and states w1, w2 computes two values. The new state is w = rq(u·2^CFRAC − b1·w1 − b2·w2). The output is y = rq(a0·w + a1·w1 + a2·w2). Here rq is R4 rounding by CFRAC bits followed by R3 clamping. On an enabled edge, w2 takes w1 and w1 takes w. The b0 coefficient has no effect.
- R6: The filter has (ORDER+1)/2 sections, rounded down. For odd ORDER the last section is first-order: w = rq(u·2^CFRAC − b1·w1) and y = rq(a0·w + a1·w1). Its a2 and b2 coefficients have no effect.
- R7: Each section output is registered, and so is the gain stage. A sample therefore reaches `yout` on the (sections+1)-th enabled edge after it is presented. With the defaults, an isolated sample of 16000 gives 0, 0, then 2442.
- R8: On an edge with `ce` low, no register changes and `yout` holds. After such a gap, the output sequence matches a run with the gap removed.
- R9: COEF packs six CW-bit fields per section, section 0 in the least significant bits. Within a section the field index j sits at bits [(6k+j)·CW +: CW]. The fields are ordered a0 = 0, a1 = 1, a2 = 2, b0 = 3, b1 = 4, b2 = 5.
- R10: After `rst_n` rises, the first two clock edges leave every register cleared, whatever `ce` and `xin` are. The third edge is the first one that can take a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release resynchronised inside |
| ce | input | 1 | Clock enable, high takes one sample per edge |
| xin | input | XW | Signed input sample |
| yout | output | DW | Signed filtered output, registered |

## Verification
Clamping and the clock enable meet in one cycle when full-scale bursts drive the gain stage and both sections into their limits while `ce` drops at random. The bench judges this by checking that `yout` holds through each gap and that the clamped state then resumes exactly as a bit-true model of the recursion predicts. A second overlap puts the reset-release window and the enable together. Samples with `ce` high are offered during the two edges after `rst_n` rises, and the model accepts none of them. Half-way rounding ties are also placed on a path where the next section rounds again in the same flow.

// File: rtl/iir_pkg.sv
package iir_pkg;
  // Coefficient fields per section; the slot at index 3 (b0) is reserved.
  localparam int unsigned COEF_PER_SEC = 6;
  localparam int unsigned IDX_A0 = 0;
  localparam int unsigned IDX_A1 = 1;
  localparam int unsigned IDX_A2 = 2;
  localparam int unsigned IDX_B1 = 4;
  localparam int unsigned IDX_B2 = 5;

  function automatic int sec_count(input int order);
    return (order + 1) / 2;
  endfunction
endpackage

// File: rtl/iir_rst_sync.sv
module iir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_ok_n = stage2_q;
endmodule

// File: rtl/iir_rnd_sat.sv
module iir_rnd_sat #(
  parameter int IW = 35,
  parameter int OW = 16,
  parameter int SH = 14
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

  logic signed [IW:0] ext;
  logic signed [IW:0] shifted;
  logic               fits;

  assign ext = {din[IW-1], din};

  generate
    if (SH == 0) begin : g_noshift
      assign shifted = ext;
    end else begin : g_shift
      localparam logic signed [IW:0] HALF = (IW+1)'(1) <<< (SH - 1);
      logic signed [IW:0] biased;
      assign biased  = ext + HALF;
      assign shifted = biased >>> SH;
    end
  endgenerate

  // Value fits when every bit above the output sign bit copies it.
  assign fits = (&shifted[IW:OW-1]) || !(|shifted[IW:OW-1]);

  always_comb begin
    if (fits) begin
      dout = shifted[OW-1:0];
    end else if (shifted[IW]) begin
      dout = MINV;
    end else begin
      dout = MAXV;
    end
  end
endmodule

// File: rtl/iir_biquad.sv
module iir_biquad #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CFRAC = 14,
  parameter logic signed [CW-1:0] A0 = '0,
  parameter logic signed [CW-1:0] A1 = '0,
  parameter logic signed [CW-1:0] A2 = '0,
  parameter logic signed [CW-1:0] B1 = '0,
  parameter logic signed [CW-1:0] B2 = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [DW-1:0] u,
  output logic signed [DW-1:0] y
);
  localparam int AW = DW + CW + 3;
  localparam logic signed [AW-1:0] A0X = AW'(A0);
  localparam logic signed [AW-1:0] A1X = AW'(A1);
  localparam logic signed [AW-1:0] A2X = AW'(A2);
  localparam logic signed [AW-1:0] B1X = AW'(B1);
  localparam logic signed [AW-1:0] B2X = AW'(B2);

  logic signed [DW-1:0] w1_q, w2_q, y_q;
  logic signed [DW-1:0] w_d, y_d;
  logic signed [AW-1:0] u_x, w1_x, w2_x, wn_x;
  logic signed [AW-1:0] acc_w, acc_y;

  assign u_x   = AW'(u);
  assign w1_x  = AW'(w1_q);
  assign w2_x  = AW'(w2_q);
  assign acc_w = (u_x <<< CFRAC) - B1X * w1_x - B2X * w2_x;

  iir_rnd_sat #(.IW(AW), .OW(DW), .SH(CFRAC)) u_rq_w (
    .din (acc_w),
    .dout(w_d)
  );

  assign wn_x  = AW'(w_d);
  assign acc_y = A0X * wn_x + A1X * w1_x + A2X * w2_x;

  iir_rnd_sat #(.IW(AW), .OW(DW), .SH(CFRAC)) u_rq_y (
    .din (acc_y),
    .dout(y_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      w2_q <= '0;
      y_q  <= '0;
    end else if (ce) begin
      w1_q <= w_d;
      w2_q <= w1_q;
      y_q  <= y_d;
    end
  end

  assign y = y_q;
endmodule

// File: rtl/iir_first_order.sv
module iir_first_order #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CFRAC = 14,
  parameter logic signed [CW-1:0] A0 = '0,
  parameter logic signed [CW-1:0] A1 = '0,
  parameter logic signed [CW-1:0] B1 = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [DW-1:0] u,
  output logic signed [DW-1:0] y
);
  localparam int AW = DW + CW + 3;
  localparam logic signed [AW-1:0] A0X = AW'(A0);
  localparam logic signed [AW-1:0] A1X = AW'(A1);
  localparam logic signed [AW-1:0] B1X = AW'(B1);

  logic signed [DW-1:0] w1_q, y_q;
  logic signed [DW-1:0] w_d, y_d;
  logic signed [AW-1:0] u_x, w1_x, wn_x;
  logic signed [AW-1:0] acc_w, acc_y;

  assign u_x   = AW'(u);
  assign w1_x  = AW'(w1_q);
  assign acc_w = (u_x <<< CFRAC) - B1X * w1_x;

  iir_rnd_sat #(.IW(AW), .OW(DW), .SH(CFRAC)) u_rq_w (
    .din (acc_w),
    .dout(w_d)
  );

  assign wn_x  = AW'(w_d);
  assign acc_y = A0X * wn_x + A1X * w1_x;

  iir_rnd_sat #(.IW(AW), .OW(DW), .SH(CFRAC)) u_rq_y (
    .din (acc_y),
    .dout(y_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      y_q  <= '0;
    end else if (ce) begin
      w1_q <= w_d;
      y_q  <= y_d;
    end
  end

  assign y = y_q;
endmodule

// File: rtl/iir_cascade.sv
module iir_cascade #(
  parameter int ORDER = 3,
  parameter int XW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CFRAC = 14,
  parameter int GSH   = 14,
  parameter logic signed [CW-1:0] GAIN = 16'sd20000,
  parameter logic [((ORDER+1)/2)*6*CW-1:0] COEF = {
    16'h0BB8, 16'hE800, 16'h4000, 16'h1388, 16'h2000, 16'h2000,
    16'h1000, 16'hE000, 16'h4000, 16'h1000, 16'h2000, 16'h1000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [XW-1:0] xin,
  output logic signed [DW-1:0] yout
);
  import iir_pkg::*;

  localparam int NSEC = sec_count(ORDER);
  localparam bit ODD  = (ORDER % 2) == 1;
  localparam int PW   = XW + CW;
  localparam int SW   = int'(COEF_PER_SEC) * CW;

  logic                 rst_ok_n;
  logic signed [PW-1:0] g_prod;
  logic signed [DW-1:0] g_d;
  logic signed [DW-1:0] gain_q;
  logic signed [DW-1:0] link [NSEC+1];

  iir_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_ok_n(rst_ok_n)
  );

  assign g_prod = PW'(xin) * PW'(GAIN);

  iir_rnd_sat #(.IW(PW), .OW(DW), .SH(GSH)) u_rq_gain (
    .din (g_prod),
    .dout(g_d)
  );

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      gain_q <= '0;
    end else if (ce) begin
      gain_q <= g_d;
    end
  end

  assign link[0] = gain_q;

  generate
    for (genvar k = 0; k < NSEC; k++) begin : g_sec
      if (ODD && (k == NSEC - 1)) begin : g_fo
        iir_first_order #(
          .DW(DW), .CW(CW), .CFRAC(CFRAC),
          .A0(COEF[k*SW + int'(IDX_A0)*CW +: CW]),
          .A1(COEF[k*SW + int'(IDX_A1)*CW +: CW]),
          .B1(COEF[k*SW + int'(IDX_B1)*CW +: CW])
        ) u_fo (
          .clk  (clk),
          .rst_n(rst_ok_n),
          .ce   (ce),
          .u    (link[k]),
          .y    (link[k+1])
        );
      end else begin : g_bq
        iir_biquad #(
          .DW(DW), .CW(CW), .CFRAC(CFRAC),
          .A0(COEF[k*SW + int'(IDX_A0)*CW +: CW]),
          .A1(COEF[k*SW + int'(IDX_A1)*CW +: CW]),
          .A2(COEF[k*SW + int'(IDX_A2)*CW +: CW]),
          .B1(COEF[k*SW + int'(IDX_B1)*CW +: CW]),
          .B2(COEF[k*SW + int'(IDX_B2)*CW +: CW])
        ) u_bq (
          .clk  (clk),
          .rst_n(rst_ok_n),
          .ce   (ce),
          .u    (link[k]),
          .y    (link[k+1])
        );
      end
    end
  endgenerate

  assign yout = link[NSEC];
endmodule

// File: rtl/iir_cascade_chk.sv
module iir_cascade_chk #(
  parameter int XW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter logic signed [CW-1:0] GAIN = 16'sd20000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_ok_n,
  input logic                 ce,
  input logic signed [XW-1:0] xin,
  input logic signed [DW-1:0] gain_q,
  input logic signed [DW-1:0] yout
);
  // R1: reset input low clears the output and the gain register
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (yout == '0) && (gain_q == '0));

  // R10: while the resynchronised reset is still active, output stays zero
  assert_release_wait_R10: assert property (@(posedge clk)
    !rst_ok_n |=> (yout == '0));

  // R2: a zero sample taken by the gain stage yields zero
  assert_gain_zero_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ce && (xin == '0)) |=> (gain_q == '0));

  // R3: clamping keeps the sign, no wrap on overflow
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ce && (xin > 0) && (GAIN > 0)) |=> (gain_q >= 0));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ce && (xin < 0) && (GAIN > 0)) |=> (gain_q <= 0));

  // R8: disabled edges leave the output and gain register alone
  assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !ce |=> ($stable(yout) && $stable(gain_q)));
endmodule

bind iir_cascade iir_cascade_chk #(
  .XW(XW), .DW(DW), .CW(CW), .GAIN(GAIN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_ok_n(rst_ok_n),
  .ce      (ce),
  .xin     (xin),
  .gain_q  (gain_q),
  .yout    (yout)
);

// File: tb/iir_cascade_tb_top.sv
module iir_cascade_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ORDER = 3;
  localparam int NSEC  = (ORDER + 1) / 2;
  localparam int XW    = 16;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int CFRAC = 14;
  localparam int GSH   = 14;
  localparam logic signed [CW-1:0] GAIN = 16'sd20000;
  localparam logic [NSEC*6*CW-1:0] COEF = {
    16'h0BB8, 16'hE800, 16'h4000, 16'h1388, 16'h2000, 16'h2000,
    16'h1000, 16'hE000, 16'h4000, 16'h1000, 16'h2000, 16'h1000};

  logic                 clk;
  logic                 rst_n;
  logic                 ce;
  logic signed [XW-1:0] xin;
  logic signed [DW-1:0] yout;

  int n_tests;
  int n_fail;
  int warm;
  bit done;

  longint mg;
  longint mw1 [NSEC];
  longint mw2 [NSEC];
  longint my  [NSEC];

  iir_cascade #(
    .ORDER(ORDER), .XW(XW), .DW(DW), .CW(CW), .CFRAC(CFRAC),
    .GSH(GSH), .GAIN(GAIN), .COEF(COEF)
  ) dut_i (
    .clk (clk),
    .rst_n(rst_n),
    .ce  (ce),
    .xin (xin),
    .yout(yout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint rq(input longint v, input int sh);
    longint r, hi, lo;
    r  = (sh > 0) ? ((v + (64'sd1 <<< (sh - 1))) >>> sh) : v;
    hi = (64'sd1 <<< (DW - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  function automatic longint cf(input int k, input int j);
    return longint'($signed(COEF[(k*6+j)*CW +: CW]));
  endfunction

  task automatic model_clear();
    mg = 0;
    for (int k = 0; k < NSEC; k++) begin
      mw1[k] = 0; mw2[k] = 0; my[k] = 0;
    end
  endtask

  task automatic model_step(input longint x);
    longint ng, u, aw, w, ay;
    longint nw1 [NSEC];
    longint nw2 [NSEC];
    longint ny  [NSEC];
    ng = rq(x * longint'(GAIN), GSH);
    for (int k = 0; k < NSEC; k++) begin
      u = (k == 0) ? mg : my[k-1];
      if ((ORDER % 2 == 1) && (k == NSEC - 1)) begin
        aw = u * (64'sd1 <<< CFRAC) - cf(k, 4) * mw1[k];
        w  = rq(aw, CFRAC);
        ay = cf(k, 0) * w + cf(k, 1) * mw1[k];
        nw2[k] = 0;
      end else begin
        aw = u * (64'sd1 <<< CFRAC) - cf(k, 4) * mw1[k] - cf(k, 5) * mw2[k];
        w  = rq(aw, CFRAC);
        ay = cf(k, 0) * w + cf(k, 1) * mw1[k] + cf(k, 2) * mw2[k];
        nw2[k] = mw1[k];
      end
      nw1[k] = w;
      ny[k]  = rq(ay, CFRAC);
    end
    mg = ng;
    for (int k = 0; k < NSEC; k++) begin
      mw1[k] = nw1[k]; mw2[k] = nw2[k]; my[k] = ny[k];
    end
  endtask

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: inputs set at the falling edge, output sampled at the next one.
  task automatic cyc(input longint x, input logic e, input string tag);
    longint prev;
    xin  = XW'(x);
    ce   = e;
    prev = longint'(yout);
    @(posedge clk);
    if (rst_n) begin
      if (warm < 2) warm++;
      else if (e) model_step(x);
    end
    @(negedge clk);
    check(tag, longint'(yout), my[NSEC-1]);
    if (!e && rst_n) check({tag, " R8 hold"}, longint'(yout), prev);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", longint'(yout), 0);
    model_clear();
    warm = 0;
    cyc(500, 1'b1, "R1 in reset");
    cyc(-700, 1'b1, "R1 in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    int unsigned r;
    n_tests = 0; n_fail = 0; done = 1'b0; warm = 0;
    void'($urandom(32'd13579));
    rst_n = 1'b0; ce = 1'b0; xin = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset state", longint'(yout), 0);
    do_reset();

    // R10: enabled samples during the release window are not taken
    cyc(1000, 1'b1, "R10 release edge 1");
    cyc(1000, 1'b1, "R10 release edge 2");
    check("R10 window count", warm, 2);
    for (int i = 0; i < 6; i++) cyc(1000, 1'b1, "R10 after release");

    // R7 and R4: isolated sample, output on third enabled edge
    do_reset();
    cyc(0, 1'b1, "R10 warm");
    cyc(0, 1'b1, "R10 warm");
    cyc(16000, 1'b1, "R7 lat edge 1");
    check("R7 zero after 1", longint'(yout), 0);
    cyc(0, 1'b1, "R7 lat edge 2");
    check("R7 zero after 2", longint'(yout), 0);
    cyc(0, 1'b1, "R7 lat edge 3");
    check("R7 R4 impulse value", longint'(yout), 2442);
    // R5 R6 R9: rest of the impulse response
    for (int i = 0; i < 30; i++) cyc(0, 1'b1, "R5 R6 R9 impulse tail");

    // R4: half-way ties at the gain stage
    for (int i = 0; i < 8; i++) cyc(256, 1'b1, "R4 tie positive");
    for (int i = 0; i < 8; i++) cyc(-256, 1'b1, "R4 tie negative");

    // R3: full-scale steps drive clamping in every stage
    for (int i = 0; i < 40; i++) cyc(32767, 1'b1, "R3 positive full scale");
    for (int i = 0; i < 40; i++) cyc(-32768, 1'b1, "R3 negative full scale");
    for (int i = 0; i < 20; i++) cyc((i % 2) ? 32767 : -32768, 1'b1, "R3 alternating");

    // R8: gaps in the enable during a saturated burst
    for (int i = 0; i < 60; i++) begin
      r = $urandom;
      cyc((r[0]) ? 32767 : -32768, (r[3:1] != 3'd0), "R8 R3 burst gaps");
    end

    // R2 R5 R6 R8: random samples, mixed amplitudes and enable
    for (int i = 0; i < 3000; i++) begin
      longint x;
      r = $urandom;
      if (r[1:0] == 2'd0) x = longint'($signed(16'($urandom)));
      else x = longint'($urandom % 4001) - 2000;
      cyc(x, ($urandom % 5) != 0, "R2 R5 R6 random");
    end

    // R1: reset in the middle of activity, then resume
    do_reset();
    cyc(3000, 1'b0, "R10 release idle");
    cyc(3000, 1'b1, "R10 release edge");
    for (int i = 0; i < 20; i++) cyc(3000, 1'b1, "R1 resume after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule